// File: doc/BRIEF.md
# Dual-Mode Pipelined Dot-Product Unit

This block is a shared vector multiplier for a small neural-network engine. It takes two operand vectors of `LANES*LANE_LEN` signed fixed-point elements (64 by default) and multiplies them element by element. The products go into four independent pipelined adder trees, one per contiguous group of 16 elements. Each tree gives its group's dot product, so one operand set can drive four parallel 3x3 convolutions, with the unused taps of each group driven to zero. Two further adder levels combine the four group sums into the full 64-term dot product, which a fully connected layer needs.

One operand set is accepted every clock cycle, and the pipeline never stalls. The four lane results and the total leave the block on fixed but different latencies. Each has its own valid flag, delayed from the input valid. Inside the trees the data stays at full precision. Only at the output is each result rescaled back to the sample format, by an arithmetic right shift of the fraction width, and then clamped to the signed sample range.

Top module: `dual_dot_unit`

## Requirements
- R1: Element i of a vector sits at bits `[i*18 +: 18]` of `opA`/`opB`. Lane k covers elements 16k to 16k+15. Lane k's result appears at bits `[k*18 +: 18]` of `laneSum`, equal to the rescaled sum of that lane's 16 products.
- R2: A lane result and `laneValid` appear 6 clock edges after the edge that samples the operands.
- R3: `totalSum` is the rescaled sum of all 64 products and appears 8 edges after the operands are sampled.
- R4: The total is formed from the full-precision lane sums, not from the rescaled lane outputs. When the lane outputs saturate in opposite directions, the total still shows the exact result (0 when the lanes cancel).
- R5: Rescaling is an arithmetic right shift by 10, which rounds toward minus infinity. A raw sum of -16 gives -1, and a raw sum of 16368 gives 15.
- R6: A rescaled value above 131071 is output as 131071. A value below -131072 is output as -131072.
- R7: `laneValid` repeats `inValid` delayed by 6 cycles, and `totalValid` repeats it delayed by 8 cycles. Back-to-back operand sets give back-to-back valid results.
- R8: While a valid flag is low, its matching outputs read zero, whatever operand data went in at that cycle.
- R9: When `rstN` is low, both valid flags and all outputs are cleared, and operand sets already in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand set present this cycle |
| opA | input | 1152 | First operand vector, 64 signed 18-bit elements |
| opB | input | 1152 | Second operand vector, 64 signed 18-bit elements |
| laneValid | output | 1 | The four lane results are valid |
| laneSum | output | 72 | Four signed 18-bit lane dot products |
| totalValid | output | 1 | The 64-term result is valid |
| totalSum | output | 18 | Signed 18-bit 64-term dot product |

## Verification
The lane output of one operand set and the total of the set sampled two cycles earlier leave the block in the same cycle. The bench provokes this by streaming its vector table into the unit with no gaps. Each cycle it compares the lane outputs with the set from six cycles back and the total with the set from eight cycles back, so a result taken from the wrong set, or a shifted valid flag, shows as a mismatch. Invalid slots inside the stream carry nonzero operand data, so the bench can confirm that the zeroed outputs do not pick up that data from either stream.

// File: rtl/dual_dot_pkg.sv
package dual_dot_pkg;
  // Default geometry; LANES and LANE_LEN must be powers of two, LANES >= 2.
  localparam int DEF_DATA_W   = 18;
  localparam int DEF_FRAC_W   = 10;
  localparam int DEF_LANES    = 4;
  localparam int DEF_LANE_LEN = 16;

  // Strobes from control to datapath: load the output registers.
  typedef struct packed {
    logic laneLoad;
    logic totalLoad;
  } dot_stb_t;
endpackage

// File: rtl/dual_dot_ctrl.sv
module dual_dot_ctrl #(
  parameter int LANE_LAT  = 6,
  parameter int TOTAL_LAT = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output dual_dot_pkg::dot_stb_t  stb,
  output logic                    laneValid,
  output logic                    totalValid
);
  // vPipe[k] holds inValid after k+1 edges
  logic [TOTAL_LAT-2:0] vPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPipe      <= '0;
      laneValid  <= 1'b0;
      totalValid <= 1'b0;
    end else begin
      vPipe      <= {vPipe[TOTAL_LAT-3:0], inValid};
      laneValid  <= stb.laneLoad;
      totalValid <= stb.totalLoad;
    end
  end

  always_comb begin
    stb.laneLoad  = vPipe[LANE_LAT-2];
    stb.totalLoad = vPipe[TOTAL_LAT-2];
  end
endmodule

// File: rtl/dual_dot_datapath.sv
module dual_dot_datapath #(
  parameter int DATA_W   = 18,
  parameter int FRAC_W   = 10,
  parameter int LANES    = 4,
  parameter int LANE_LEN = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dual_dot_pkg::dot_stb_t        stb,
  input  logic [LANES*LANE_LEN*DATA_W-1:0] opA,
  input  logic [LANES*LANE_LEN*DATA_W-1:0] opB,
  output logic [LANES*DATA_W-1:0]       laneSum,
  output logic [DATA_W-1:0]             totalSum
);
  localparam int LANE_LVL = $clog2(LANE_LEN);
  localparam int TOT_LVL  = $clog2(LANES);
  localparam int PROD_W   = 2 * DATA_W;
  localparam int LANE_W   = PROD_W + LANE_LVL;
  localparam int TOT_W    = LANE_W + TOT_LVL;
  localparam logic signed [TOT_W-1:0] SAT_HI = TOT_W'((64'sd1 <<< (DATA_W-1)) - 64'sd1);
  localparam logic signed [TOT_W-1:0] SAT_LO = -SAT_HI - TOT_W'(1);

  logic signed [LANE_W-1:0] laneRoot [LANES];

  // One heap-ordered adder tree per lane; each level is a register stage.
  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic signed [LANE_W-1:0] tree [1:2*LANE_LEN-1];
    logic signed [PROD_W-1:0] prod [LANE_LEN];

    for (genvar j = 0; j < LANE_LEN; j++) begin : gMul
      logic signed [DATA_W-1:0] aEl, bEl;
      assign aEl = opA[(l*LANE_LEN+j)*DATA_W +: DATA_W];
      assign bEl = opB[(l*LANE_LEN+j)*DATA_W +: DATA_W];
      assign prod[j] = aEl * bEl;
    end

    always_ff @(posedge clk) begin
      for (int j = 0; j < LANE_LEN; j++)
        tree[LANE_LEN+j] <= LANE_W'(prod[j]);
      for (int n = 1; n < LANE_LEN; n++)
        tree[n] <= tree[2*n] + tree[2*n+1];
    end

    assign laneRoot[l] = tree[1];
  end

  // Cross-lane tree on the full-precision lane roots.
  logic signed [TOT_W-1:0] totNode [1:LANES-1];
  logic signed [TOT_W-1:0] allNode [1:2*LANES-1];

  always_comb begin
    for (int n = 1; n < LANES; n++)
      allNode[n] = totNode[n];
    for (int k = 0; k < LANES; k++)
      allNode[LANES+k] = TOT_W'(laneRoot[k]);
  end

  always_ff @(posedge clk) begin
    for (int n = 1; n < LANES; n++)
      totNode[n] <= allNode[2*n] + allNode[2*n+1];
  end

  function automatic logic [DATA_W-1:0] rescale(input logic signed [TOT_W-1:0] x);
    logic signed [TOT_W-1:0] s;
    s = x >>> FRAC_W;
    if (s > SAT_HI)      s = SAT_HI;
    else if (s < SAT_LO) s = SAT_LO;
    return s[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneSum  <= '0;
      totalSum <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        laneSum[l*DATA_W +: DATA_W] <= stb.laneLoad ? rescale(TOT_W'(laneRoot[l])) : '0;
      totalSum <= stb.totalLoad ? rescale(totNode[1]) : '0;
    end
  end
endmodule

// File: rtl/dual_dot_unit.sv
module dual_dot_unit #(
  parameter int DATA_W   = dual_dot_pkg::DEF_DATA_W,
  parameter int FRAC_W   = dual_dot_pkg::DEF_FRAC_W,
  parameter int LANES    = dual_dot_pkg::DEF_LANES,
  parameter int LANE_LEN = dual_dot_pkg::DEF_LANE_LEN
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             inValid,
  input  logic [LANES*LANE_LEN*DATA_W-1:0] opA,
  input  logic [LANES*LANE_LEN*DATA_W-1:0] opB,
  output logic                             laneValid,
  output logic [LANES*DATA_W-1:0]          laneSum,
  output logic                             totalValid,
  output logic [DATA_W-1:0]                totalSum
);
  // multiplier stage + tree levels + output stage
  localparam int LANE_LAT  = $clog2(LANE_LEN) + 2;
  localparam int TOTAL_LAT = LANE_LAT + $clog2(LANES);

  dual_dot_pkg::dot_stb_t stb;

  dual_dot_ctrl #(.LANE_LAT(LANE_LAT), .TOTAL_LAT(TOTAL_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .stb(stb),
    .laneValid(laneValid), .totalValid(totalValid)
  );

  dual_dot_datapath #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .LANES(LANES), .LANE_LEN(LANE_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .opA(opA), .opB(opB),
    .laneSum(laneSum), .totalSum(totalSum)
  );
endmodule

// File: rtl/dual_dot_checker.sv
module dual_dot_checker #(
  parameter int LANE_LAT  = 6,
  parameter int TOTAL_LAT = 8,
  parameter int DATA_W    = 18,
  parameter int LANES     = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    laneValid,
  input logic                    totalValid,
  input logic [LANES*DATA_W-1:0] laneSum,
  input logic [DATA_W-1:0]       totalSum
);
  // Independent record of input valid history
  logic [TOTAL_LAT-1:0] seen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= '0;
    else       seen <= {seen[TOTAL_LAT-2:0], inValid};
  end

  assert_lane_lag_R2: assert property (@(posedge clk) disable iff (!rstN)
    laneValid == seen[LANE_LAT-1]);

  assert_total_lag_R7: assert property (@(posedge clk) disable iff (!rstN)
    totalValid == seen[TOTAL_LAT-1]);

  assert_lane_idle_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !laneValid |-> laneSum == '0);

  assert_total_idle_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !totalValid |-> totalSum == '0);

  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!laneValid && !totalValid));
endmodule

bind dual_dot_unit dual_dot_checker #(
  .LANE_LAT(LANE_LAT), .TOTAL_LAT(TOTAL_LAT), .DATA_W(DATA_W), .LANES(LANES)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .laneValid(laneValid),
  .totalValid(totalValid), .laneSum(laneSum), .totalSum(totalSum)
);

// File: tb/dual_dot_unit_tb.sv
module dual_dot_unit_tb;
  localparam int DW = 18, FW = 10, NL = 4, LL = 16, VL = NL * LL;
  localparam longint SHI = (64'sd1 <<< (DW-1)) - 1;
  localparam longint SLO = -SHI - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, inValid;
  logic [VL*DW-1:0] opA, opB;
  logic laneValid, totalValid;
  logic [NL*DW-1:0] laneSum;
  logic [DW-1:0] totalSum;

  dual_dot_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .laneValid(laneValid), .laneSum(laneSum),
    .totalValid(totalValid), .totalSum(totalSum)
  );

  int nRun = 0, nFail = 0;

  typedef struct packed {
    logic vld; int aBase; int aStep; int bBase; int bStep; int negFrom;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1024, 0, 1024, 0, 64},
    '{1'b1, 0, 1, 1024, 0, 64},
    '{1'b1, -1, 0, 1, 0, 64},
    '{1'b0, 500, 3, -700, 5, 64},
    '{1'b1, 131071, 0, 131071, 0, 64},
    '{1'b1, -131072, 0, 131071, 0, 64},
    '{1'b1, 131071, 0, 131071, 0, 32},
    '{1'b1, -2000, 60, 300, -7, 64},
    '{1'b0, 9999, 1, -9999, 1, 64},
    '{1'b1, 1023, 0, 1, 0, 64},
    '{1'b1, 3, 0, -100, 0, 40}
  };

  function automatic string tagOf(int i);
    case (i)
      2, 9:    return "R5";
      4, 5:    return "R6";
      6:       return "R4";
      3, 8:    return "R8";
      default: return "R1";
    endcase
  endfunction

  function automatic int elemVal(int base, int step, int negFrom, int k);
    int v;
    v = base + step * k;
    if (k >= negFrom) v = -v;
    return v;
  endfunction

  function automatic longint rescaleRef(longint s);
    longint q;
    q = s >>> FW;
    if (q > SHI) q = SHI;
    if (q < SLO) q = SLO;
    return q;
  endfunction

  longint expLane [NV][NL];
  longint expTot [NV];

  task automatic check(string tag, string what, longint act, longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkOutputs(int li, int ti);
    logic lv, tv;
    logic signed [DW-1:0] t;
    lv = (li >= 0 && li < NV) ? TBL[li].vld : 1'b0;
    tv = (ti >= 0 && ti < NV) ? TBL[ti].vld : 1'b0;
    check("R7", "laneValid", longint'(laneValid), longint'(lv));
    check("R7", "totalValid", longint'(totalValid), longint'(tv));
    for (int l = 0; l < NL; l++) begin
      t = laneSum[l*DW +: DW];
      check(lv ? tagOf(li) : "R8", $sformatf("lane%0d", l), longint'(t), lv ? expLane[li][l] : 0);
    end
    t = totalSum;
    check(tv ? (tagOf(ti) == "R1" ? "R3" : tagOf(ti)) : "R8", "total", longint'(t), tv ? expTot[ti] : 0);
  endtask

  task automatic driveVec(int i);
    inValid = TBL[i].vld;
    for (int k = 0; k < VL; k++) begin
      opA[k*DW +: DW] = DW'(elemVal(TBL[i].aBase, TBL[i].aStep, TBL[i].negFrom, k));
      opB[k*DW +: DW] = DW'(elemVal(TBL[i].bBase, TBL[i].bStep, 64, k));
    end
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL R7 watchdog actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      longint tot;
      tot = 0;
      for (int l = 0; l < NL; l++) begin
        longint s;
        s = 0;
        for (int j = 0; j < LL; j++) begin
          int k;
          k = l * LL + j;
          s += longint'(elemVal(TBL[i].aBase, TBL[i].aStep, TBL[i].negFrom, k)) *
               longint'(elemVal(TBL[i].bBase, TBL[i].bStep, 64, k));
        end
        expLane[i][l] = rescaleRef(s);
        tot += s;
      end
      expTot[i] = rescaleRef(tot);
    end

    rstN = 1'b0; inValid = 1'b0; opA = '0; opB = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    checkOutputs(-1, -1);
    rstN = 1'b1;

    // Streamed table: lanes lag 6 cycles (R2), total lags 8 (R3)
    for (int c = 0; c < NV + 8; c++) begin
      @(negedge clk);
      checkOutputs(c - 6, c - 8);
      if (c < NV) driveVec(c);
      else begin inValid = 1'b0; opA = '0; opB = '0; end
    end

    // R9: reset with operand sets in flight discards them
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      driveVec(0);
    end
    @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b0;
    #1;
    check("R9", "laneValid in reset", longint'(laneValid), 0);
    check("R9", "totalValid in reset", longint'(totalValid), 0);
    check("R9", "laneSum in reset", longint'(laneSum), 0);
    check("R9", "totalSum in reset", longint'(totalSum), 0);
    @(negedge clk);
    rstN = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      check("R9", "laneValid after reset", longint'(laneValid), 0);
      check("R9", "totalValid after reset", longint'(totalValid), 0);
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule